// File: doc/BRIEF.md
# Four-Voice Wavetable Oscillator Mixer

This block turns four looping wavetables into one mixed sample stream. Each voice owns a 24-bit phase accumulator and a 24-bit increment, both in 9.15 fixed point. The upper nine phase bits pick one of 512 table entries. The four tables live in two external 1024-byte sample banks. Voices 0 and 1 share bank A, voices 2 and 3 share bank B, and the odd voice of each pair uses the upper half of its bank.

A local tick generator sets the sample rate. Its divider is chosen by a 2-bit rate code. On every tick each phase moves forward by its increment. The block then reads the four table bytes over two cycles, one read per bank per cycle. Each byte is turned into a signed value by inverting its top bit, and the four values are added into a 10-bit signed sum. That sum drives both the left and the right output, and a one-cycle strobe marks each new value.

A byte-wide write port loads the registers. The rate code sits at address 0x07. The phase of voice n sits at 0x10+8n and its increment at 0x14+8n. The block runs only while the mode input selects wavetable operation.

Top module: `wt_mixer4`

## Requirements
- R1: While reset is asserted, and up to the second rising clock edge after `rst_n` rises, `mix_left` and `mix_right` read 0 and `mix_strobe` is low. Reset clears every phase and every increment to 0 and sets the rate code to 0.
- R2: A write to address 0x10+8n+k loads one byte of the voice n phase, and a write to 0x14+8n+k loads one byte of the voice n increment. The bytes are big-endian: k=1 loads bits 23:16, k=2 loads bits 15:8 and k=3 loads bits 7:0. A write with k=0, or to any address outside 0x07 and 0x10..0x2F, changes nothing.
- R3: On every tick, each voice's phase becomes (phase + increment) mod 2^24. Between ticks a phase changes only when it is written.
- R4: A voice's table index is bits 23:15 of its phase after the tick update. Voices 0 and 1 read bank A, voices 2 and 3 read bank B. Within its bank, an even voice reads address index and an odd voice reads 0x200 + index.
- R5: Each fetched byte b counts as the signed value (b XOR 0x80), so 0x00 gives -128 and 0xFF gives +127. The four values are added into a 10-bit two's-complement result, which appears on both `mix_left` and `mix_right`.
- R6: Bank read data is expected one cycle after the address. For a tick in cycle T, the new sum appears, and `mix_strobe` is high for exactly one cycle, in cycle T+4. Between strobes the outputs hold their value.
- R7: The rate code is written to address 0x07 bits 1:0. Code 0 gives a tick every DIV_R0 cycles, code 2 every DIV_R2 cycles and code 3 every DIV_R3 cycles. Writing the code restarts the count. Code 1 stops all ticks, so phases and outputs hold.
- R8: While `mode_sel` is not 2, no tick occurs and any fetch in progress is dropped. From the next cycle on, the outputs read 0 and the strobe is low. Register writes still take effect.
- R9: A phase byte written in a tick cycle replaces that byte of the advanced phase. An increment written in a tick cycle is used only from the next tick. A write to one voice never changes another voice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Operating mode; 2 enables wavetable synthesis |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte address |
| cfg_wdata | input | 8 | Register write data |
| bank_a_addr | output | 10 | Read address into sample bank A |
| bank_a_rdata | input | 8 | Bank A read data, one cycle after the address |
| bank_b_addr | output | 10 | Read address into sample bank B |
| bank_b_rdata | input | 8 | Bank B read data, one cycle after the address |
| mix_left | output | 10 | Signed mixed sample, left |
| mix_right | output | 10 | Signed mixed sample, right |
| mix_strobe | output | 1 | One-cycle pulse marking a new mixed sample |

## Verification
The assertions check, on every cycle, several rules that hold at all times:
- phases are held between ticks, and on a tick they advance by exactly the increment;
- no tick occurs under rate code 1 or outside wavetable mode;
- the outputs are cleared after the mode is left, and the strobe is a single pulse;
- the outputs do not change without a strobe;
- the lower half of each bank is read first and the upper half second.

Other behaviour shows only through the bench's scenarios, because it depends on sample data and on when writes land:
- the big-endian byte placement;
- the mapping of voices onto bank halves and the top-bit inversion;
- the extreme sums -512 and +508;
- the divider length for each rate code;
- writes that coincide with a tick.

// File: rtl/wt_mix_pkg.sv
package wt_mix_pkg;

  localparam logic [1:0] MODE_WAVETABLE  = 2'd2;
  localparam logic [1:0] RATE_STOPPED    = 2'd1;
  localparam logic [7:0] ADDR_RATE       = 8'h07;
  localparam logic [7:0] ADDR_VOICE_BASE = 8'h10;

  typedef enum logic [1:0] {
    FETCH_IDLE,
    FETCH_LO,
    FETCH_HI,
    FETCH_SUM
  } fetch_state_e;

endpackage

// File: rtl/wt_tick_gen.sv
module wt_tick_gen
  import wt_mix_pkg::*;
#(
  parameter int DIV_R0 = 16,
  parameter int DIV_R2 = 17,
  parameter int DIV_R3 = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run_req,
  input  logic       rate_we,
  input  logic [1:0] rate_wdata,
  output logic       tick,
  output logic [1:0] rate_code
);

  localparam int DIV_MAX = (DIV_R0 > DIV_R2) ?
                           ((DIV_R0 > DIV_R3) ? DIV_R0 : DIV_R3) :
                           ((DIV_R2 > DIV_R3) ? DIV_R2 : DIV_R3);
  localparam int CNT_W = $clog2(DIV_MAX + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d, last_cnt;
  logic [1:0]       rate_q, rate_d;
  logic             run;

  // divider end value for the current code
  always_comb begin
    case (rate_q)
      2'd0:    last_cnt = CNT_W'(DIV_R0 - 1);
      2'd2:    last_cnt = CNT_W'(DIV_R2 - 1);
      2'd3:    last_cnt = CNT_W'(DIV_R3 - 1);
      default: last_cnt = '0;
    endcase
  end

  always_comb begin
    run    = run_req && (rate_q != RATE_STOPPED);
    tick   = run && (cnt_q == last_cnt);
    rate_d = rate_we ? rate_wdata : rate_q;
    if (!run || rate_we) begin
      cnt_d = '0;
    end else if (tick) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      rate_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (rate_we) begin
        rate_q <= rate_d;
      end
    end
  end

  assign rate_code = rate_q;

endmodule

// File: rtl/wt_voice_regs.sv
module wt_voice_regs #(
  parameter int NUM_VOICES = 4,
  parameter int PHASE_W    = 24,
  parameter int IDX_W      = 9,
  parameter int VSEL_W     = $clog2(NUM_VOICES),
  parameter int LANE_W     = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          tick,
  input  logic                          wr_en,
  input  logic [VSEL_W-1:0]             wr_voice,
  input  logic                          wr_incr,
  input  logic [LANE_W-1:0]             wr_lane,
  input  logic [7:0]                    wr_data,
  output logic [NUM_VOICES*PHASE_W-1:0] phase_flat,
  output logic [NUM_VOICES*PHASE_W-1:0] incr_flat,
  output logic [NUM_VOICES*IDX_W-1:0]   idx_flat
);

  localparam int BYTES = PHASE_W / 8;

  for (genvar v = 0; v < NUM_VOICES; v++) begin : g_voice
    logic [PHASE_W-1:0] ph_q, ph_d, inc_q, inc_d;
    logic [IDX_W-1:0]   idx_q;
    logic               hit, ph_en, inc_en;

    // next state: tick advance first, then any byte write on top of it
    always_comb begin
      hit   = wr_en && (wr_voice == VSEL_W'(v));
      ph_d  = tick ? (ph_q + inc_q) : ph_q;
      inc_d = inc_q;
      for (int b = 0; b < BYTES; b++) begin
        if (hit && (wr_lane == LANE_W'(BYTES - b))) begin
          if (wr_incr) begin
            inc_d[b*8 +: 8] = wr_data;
          end else begin
            ph_d[b*8 +: 8] = wr_data;
          end
        end
      end
      ph_en  = tick || (hit && !wr_incr);
      inc_en = hit && wr_incr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ph_q  <= '0;
        inc_q <= '0;
        idx_q <= '0;
      end else begin
        if (ph_en) begin
          ph_q <= ph_d;
        end
        if (inc_en) begin
          inc_q <= inc_d;
        end
        if (tick) begin
          idx_q <= ph_d[PHASE_W-1 -: IDX_W];
        end
      end
    end

    assign phase_flat[v*PHASE_W +: PHASE_W] = ph_q;
    assign incr_flat[v*PHASE_W +: PHASE_W]  = inc_q;
    assign idx_flat[v*IDX_W +: IDX_W]       = idx_q;
  end

endmodule

// File: rtl/wt_fetch_mix.sv
module wt_fetch_mix
  import wt_mix_pkg::*;
#(
  parameter int NUM_VOICES = 4,
  parameter int IDX_W      = 9,
  parameter int SAMPLE_W   = 8,
  parameter int MIX_W      = 10,
  parameter int ADDR_W     = IDX_W + 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        run_req,
  input  logic                        tick,
  input  logic [NUM_VOICES*IDX_W-1:0] idx_flat,
  input  logic [SAMPLE_W-1:0]         bank_a_rdata,
  input  logic [SAMPLE_W-1:0]         bank_b_rdata,
  output logic [ADDR_W-1:0]           bank_a_addr,
  output logic [ADDR_W-1:0]           bank_b_addr,
  output logic [MIX_W-1:0]            mix_q,
  output logic                        mix_strobe
);

  localparam int NUM_BANKS       = 2;
  localparam int VOICES_PER_BANK = NUM_VOICES / NUM_BANKS;

  fetch_state_e       state_q, state_d;
  logic [MIX_W-1:0]   acc_q, acc_d, mix_d, pair_sum;
  logic               acc_en, mix_en, strobe_q, strobe_d, hi_sel;
  logic [SAMPLE_W-1:0] rdata [NUM_BANKS];
  logic [ADDR_W-1:0]   addr  [NUM_BANKS];

  function automatic logic signed [MIX_W-1:0] widen(input logic [SAMPLE_W-1:0] raw);
    logic [SAMPLE_W-1:0] flip;
    flip = raw ^ SAMPLE_W'(1 << (SAMPLE_W - 1));
    return MIX_W'($signed(flip));
  endfunction

  assign hi_sel = (state_q == FETCH_HI);

  // even voice of a bank in the low half, odd voice in the upper half
  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    assign addr[g] = {hi_sel,
                      idx_flat[(g*VOICES_PER_BANK + int'(hi_sel))*IDX_W +: IDX_W]};
    if (g == 0) begin : g_a
      assign rdata[g]    = bank_a_rdata;
      assign bank_a_addr = addr[g];
    end else begin : g_b
      assign rdata[g]    = bank_b_rdata;
      assign bank_b_addr = addr[g];
    end
  end

  assign pair_sum = widen(rdata[0]) + widen(rdata[1]);

  always_comb begin
    if (!run_req) begin
      state_d = FETCH_IDLE;
    end else if (tick) begin
      state_d = FETCH_LO;
    end else begin
      case (state_q)
        FETCH_LO:  state_d = FETCH_HI;
        FETCH_HI:  state_d = FETCH_SUM;
        default:   state_d = FETCH_IDLE;
      endcase
    end
    acc_en   = (state_q == FETCH_HI);
    acc_d    = pair_sum;
    mix_en   = !run_req || (state_q == FETCH_SUM);
    mix_d    = run_req ? (acc_q + pair_sum) : '0;
    strobe_d = run_req && (state_q == FETCH_SUM);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= FETCH_IDLE;
      acc_q    <= '0;
      mix_q    <= '0;
      strobe_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      strobe_q <= strobe_d;
      if (acc_en) begin
        acc_q <= acc_d;
      end
      if (mix_en) begin
        mix_q <= mix_d;
      end
    end
  end

  assign mix_strobe = strobe_q;

endmodule

// File: rtl/wt_mixer4.sv
module wt_mixer4
  import wt_mix_pkg::*;
#(
  parameter int DIV_R0   = 16,
  parameter int DIV_R2   = 17,
  parameter int DIV_R3   = 8,
  parameter int PHASE_W  = 24,
  parameter int IDX_W    = 9,
  parameter int SAMPLE_W = 8,
  parameter int MIX_W    = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          mode_sel,
  input  logic                cfg_we,
  input  logic [7:0]          cfg_addr,
  input  logic [7:0]          cfg_wdata,
  output logic [IDX_W:0]      bank_a_addr,
  input  logic [SAMPLE_W-1:0] bank_a_rdata,
  output logic [IDX_W:0]      bank_b_addr,
  input  logic [SAMPLE_W-1:0] bank_b_rdata,
  output logic [MIX_W-1:0]    mix_left,
  output logic [MIX_W-1:0]    mix_right,
  output logic                mix_strobe
);

  localparam int NUM_VOICES = 4;
  localparam int VSEL_W     = $clog2(NUM_VOICES);
  localparam int LANE_W     = 2;
  localparam int WIN_BYTES  = NUM_VOICES * 8;

  logic [1:0]                    rst_sync_q;
  logic                          rst_n_int;
  logic                          run_req, tick, rate_we, voice_we;
  logic [1:0]                    rate_code;
  logic [7:0]                    rel_addr;
  logic [NUM_VOICES*PHASE_W-1:0] phase_flat, incr_flat;
  logic [NUM_VOICES*IDX_W-1:0]   idx_flat;
  logic [MIX_W-1:0]              mix_q;

  // reset asserts at once, releases on the second clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_int = rst_sync_q[1];

  always_comb begin
    run_req  = (mode_sel == MODE_WAVETABLE);
    rel_addr = cfg_addr - ADDR_VOICE_BASE;
    rate_we  = cfg_we && (cfg_addr == ADDR_RATE);
    voice_we = cfg_we && (cfg_addr >= ADDR_VOICE_BASE) &&
               (cfg_addr < (ADDR_VOICE_BASE + 8'(WIN_BYTES)));
  end

  wt_tick_gen #(
    .DIV_R0 (DIV_R0),
    .DIV_R2 (DIV_R2),
    .DIV_R3 (DIV_R3)
  ) u_tick (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .run_req    (run_req),
    .rate_we    (rate_we),
    .rate_wdata (cfg_wdata[1:0]),
    .tick       (tick),
    .rate_code  (rate_code)
  );

  wt_voice_regs #(
    .NUM_VOICES (NUM_VOICES),
    .PHASE_W    (PHASE_W),
    .IDX_W      (IDX_W),
    .VSEL_W     (VSEL_W),
    .LANE_W     (LANE_W)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .tick       (tick),
    .wr_en      (voice_we),
    .wr_voice   (rel_addr[3 +: VSEL_W]),
    .wr_incr    (rel_addr[2]),
    .wr_lane    (rel_addr[1:0]),
    .wr_data    (cfg_wdata),
    .phase_flat (phase_flat),
    .incr_flat  (incr_flat),
    .idx_flat   (idx_flat)
  );

  wt_fetch_mix #(
    .NUM_VOICES (NUM_VOICES),
    .IDX_W      (IDX_W),
    .SAMPLE_W   (SAMPLE_W),
    .MIX_W      (MIX_W),
    .ADDR_W     (IDX_W + 1)
  ) u_mix (
    .clk          (clk),
    .rst_n        (rst_n_int),
    .run_req      (run_req),
    .tick         (tick),
    .idx_flat     (idx_flat),
    .bank_a_rdata (bank_a_rdata),
    .bank_b_rdata (bank_b_rdata),
    .bank_a_addr  (bank_a_addr),
    .bank_b_addr  (bank_b_addr),
    .mix_q        (mix_q),
    .mix_strobe   (mix_strobe)
  );

  assign mix_left  = mix_q;
  assign mix_right = mix_q;

endmodule

// File: rtl/wt_mixer4_chk.sv
module wt_mixer4_chk #(
  parameter int PHASE_W = 24,
  parameter int IDX_W   = 9,
  parameter int MIX_W   = 10
) (
  input logic                 clk,
  input logic                 rst_n_int,
  input logic [1:0]           mode_sel,
  input logic                 cfg_we,
  input logic                 tick,
  input logic [1:0]           rate_code,
  input logic [4*PHASE_W-1:0] phase_flat,
  input logic [4*PHASE_W-1:0] incr_flat,
  input logic [IDX_W:0]       bank_a_addr,
  input logic [MIX_W-1:0]     mix_left,
  input logic                 mix_strobe
);

  // R3: with no tick and no write, phases stay put
  p_phase_hold_r3: assert property (@(posedge clk) disable iff (!rst_n_int)
    (!tick && !cfg_we) |=> $stable(phase_flat));

  // R3: voice 0 advances by its increment, wrapping at 2^24
  p_phase_step_r3: assert property (@(posedge clk) disable iff (!rst_n_int)
    (tick && !cfg_we) |=> (phase_flat[PHASE_W-1:0] ==
      PHASE_W'($past(phase_flat[PHASE_W-1:0]) + $past(incr_flat[PHASE_W-1:0]))));

  // R3: the same rule for voice 3
  p_phase_step3_r3: assert property (@(posedge clk) disable iff (!rst_n_int)
    (tick && !cfg_we) |=> (phase_flat[4*PHASE_W-1 -: PHASE_W] ==
      PHASE_W'($past(phase_flat[4*PHASE_W-1 -: PHASE_W]) + $past(incr_flat[4*PHASE_W-1 -: PHASE_W]))));

  // R7: rate code 1 stops ticks
  p_no_tick_rate1_r7: assert property (@(posedge clk) disable iff (!rst_n_int)
    (rate_code == 2'd1) |-> !tick);

  // R8: no ticks outside wavetable mode
  p_no_tick_off_r8: assert property (@(posedge clk) disable iff (!rst_n_int)
    (mode_sel != 2'd2) |-> !tick);

  // R8: outputs cleared one cycle after the mode is left
  p_mix_zero_r8: assert property (@(posedge clk) disable iff (!rst_n_int)
    (mode_sel != 2'd2) |=> ((mix_left == '0) && !mix_strobe));

  // R6: strobe lasts a single cycle
  p_strobe_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n_int)
    mix_strobe |=> !mix_strobe);

  // R6: in wavetable mode the output only changes with a strobe
  p_hold_between_r6: assert property (@(posedge clk) disable iff (!rst_n_int)
    (mode_sel == 2'd2) |=> (mix_strobe || $stable(mix_left)));

  // R4: lower half (even voice) read in the cycle after a tick
  p_lo_half_r4: assert property (@(posedge clk) disable iff (!rst_n_int)
    $past(tick) |-> !bank_a_addr[IDX_W]);

  // R4: upper half (odd voice) read in the following cycle
  p_hi_half_r4: assert property (@(posedge clk) disable iff (!rst_n_int)
    ($past(tick, 2) && $past(mode_sel == 2'd2)) |-> bank_a_addr[IDX_W]);

endmodule

bind wt_mixer4 wt_mixer4_chk #(
  .PHASE_W (PHASE_W),
  .IDX_W   (IDX_W),
  .MIX_W   (MIX_W)
) u_chk (
  .clk         (clk),
  .rst_n_int   (rst_n_int),
  .mode_sel    (mode_sel),
  .cfg_we      (cfg_we),
  .tick        (tick),
  .rate_code   (rate_code),
  .phase_flat  (phase_flat),
  .incr_flat   (incr_flat),
  .bank_a_addr (bank_a_addr),
  .mix_left    (mix_left),
  .mix_strobe  (mix_strobe)
);

// File: tb/sim_wt_mixer4.sv
module sim_wt_mixer4;

  localparam int CLK_PERIOD = 10;
  localparam int DIV0 = 16;
  localparam int DIV2 = 17;
  localparam int DIV3 = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] mode_sel;
  logic       cfg_we;
  logic [7:0] cfg_addr, cfg_wdata;
  logic [9:0] bank_a_addr, bank_b_addr, mix_left, mix_right;
  logic [7:0] bank_a_rdata, bank_b_rdata;
  logic       mix_strobe;

  logic [7:0] mem_a [1024];
  logic [7:0] mem_b [1024];

  int    vectors = 0;
  int    fails   = 0;
  bit    cmp_on  = 1'b0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  wt_mixer4 #(.DIV_R0(DIV0), .DIV_R2(DIV2), .DIV_R3(DIV3)) u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_sel     (mode_sel),
    .cfg_we       (cfg_we),
    .cfg_addr     (cfg_addr),
    .cfg_wdata    (cfg_wdata),
    .bank_a_addr  (bank_a_addr),
    .bank_a_rdata (bank_a_rdata),
    .bank_b_addr  (bank_b_addr),
    .bank_b_rdata (bank_b_rdata),
    .mix_left     (mix_left),
    .mix_right    (mix_right),
    .mix_strobe   (mix_strobe)
  );

  // registered sample banks
  always @(posedge clk) begin
    bank_a_rdata <= mem_a[bank_a_addr];
    bank_b_rdata <= mem_b[bank_b_addr];
  end

  // ---------------- reference model ----------------
  int m_rel, m_cyc, m_cnt, m_rate, m_out;
  bit m_stb;
  int m_ph [4];
  int m_inc[4];
  int q_due[$];
  int q_val[$];

  function automatic int div_of(input int code);
    case (code)
      0: return DIV0;
      2: return DIV2;
      3: return DIV3;
      default: return 0;
    endcase
  endfunction

  function automatic int sval(input logic [7:0] b);
    return int'(b) - 128;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rel = 0; m_cyc = 0; m_cnt = 0; m_rate = 0; m_out = 0; m_stb = 0;
      for (int v = 0; v < 4; v++) begin m_ph[v] = 0; m_inc[v] = 0; end
      q_due.delete(); q_val.delete();
    end else if (m_rel < 2) begin
      m_rel++;
    end else begin
      bit run, tk, rw;
      m_cyc++;
      if (mode_sel != 2'd2) begin
        m_out = 0; m_stb = 0; q_due.delete(); q_val.delete();
      end else begin
        m_stb = 0;
        if (q_due.size() > 0 && q_due[0] == m_cyc) begin
          m_out = q_val[0]; m_stb = 1;
          void'(q_due.pop_front()); void'(q_val.pop_front());
        end
      end
      run = (mode_sel == 2'd2) && (m_rate != 1);
      tk  = run && (m_cnt == div_of(m_rate) - 1);
      if (tk) for (int v = 0; v < 4; v++) m_ph[v] = (m_ph[v] + m_inc[v]) & 32'hFFFFFF;
      rw = 0;
      if (cfg_we) begin
        if (cfg_addr == 8'h07) begin
          m_rate = int'(cfg_wdata[1:0]); rw = 1;
        end else if (cfg_addr >= 8'h10 && cfg_addr < 8'h30) begin
          int rel, v, k, sh;
          rel = int'(cfg_addr) - 16; v = rel / 8; k = rel % 4;
          if (k != 0) begin
            sh = (3 - k) * 8;
            if ((rel % 8) >= 4) m_inc[v] = (m_inc[v] & ~(255 << sh)) | (int'(cfg_wdata) << sh);
            else                m_ph[v]  = (m_ph[v]  & ~(255 << sh)) | (int'(cfg_wdata) << sh);
          end
        end
      end
      if (tk) begin
        int s;
        s = sval(mem_a[m_ph[0] >> 15]) + sval(mem_a[512 + (m_ph[1] >> 15)]) +
            sval(mem_b[m_ph[2] >> 15]) + sval(mem_b[512 + (m_ph[3] >> 15)]);
        q_due.push_back(m_cyc + 3); q_val.push_back(s);
      end
      if (!run || rw || tk) m_cnt = 0; else m_cnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (cmp_on) begin
      chk($signed(mix_left) == m_out, cur_req, int'($signed(mix_left)), m_out);
      chk($signed(mix_right) == m_out, cur_req, int'($signed(mix_right)), m_out);
      chk(mix_strobe == m_stb, cur_req, int'(mix_strobe), int'(m_stb));
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wr24(input logic [7:0] base, input logic [23:0] val);
    wr(base + 8'd1, val[23:16]);
    wr(base + 8'd2, val[15:8]);
    wr(base + 8'd3, val[7:0]);
  endtask

  task automatic sync_to_tick();
    while (!(mode_sel == 2'd2 && m_rate != 1 && m_cnt == div_of(m_rate) - 1))
      @(negedge clk);
  endtask

  task automatic wait_strobe();
    for (int i = 0; i < 200 && !mix_strobe; i++) @(negedge clk);
  endtask

  // ---------------- scenarios ----------------
  initial begin
    for (int i = 0; i < 1024; i++) begin
      mem_a[i] = 8'((i * 37 + 11) & 255);
      mem_b[i] = 8'((i * 13 + 81) & 255);
    end
    mem_a[10'h1FF] = 8'h00; mem_a[10'h3FF] = 8'h00;
    mem_b[10'h1FF] = 8'h00; mem_b[10'h3FF] = 8'h00;
    mem_a[10'h1FE] = 8'hFF; mem_a[10'h3FE] = 8'hFF;
    mem_b[10'h1FE] = 8'hFF; mem_b[10'h3FE] = 8'hFF;

    rst_n = 1'b0; mode_sel = 2'd0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    repeat (3) @(negedge clk);
    cmp_on = 1'b1;
    cur_req = "R1";
    chk(mix_left == 10'd0, "R1", int'(mix_left), 0);
    chk(mix_strobe == 1'b0, "R1", int'(mix_strobe), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2: byte-wise loading, ignored lanes and addresses
    cur_req = "R2";
    wr24(8'h14, 24'h008000);
    wr24(8'h1C, 24'h010000);
    wr24(8'h24, 24'h123456);
    wr24(8'h2C, 24'hFFFFFF);
    wr24(8'h20, 24'hABCDEF);
    wr(8'h24, 8'hFF);
    wr(8'h20, 8'h77);
    wr(8'h30, 8'h55);
    wr(8'h0F, 8'h66);

    // R3/R4: run the oscillators
    cur_req = "R3";
    mode_sel = 2'd2;
    repeat (400) @(negedge clk);
    cur_req = "R4";
    wr24(8'h18, 24'h7F0000);
    wr24(8'h28, 24'hFFFF00);
    repeat (300) @(negedge clk);
    cur_req = "R6";
    repeat (200) @(negedge clk);

    // R7: rate codes
    cur_req = "R7";
    wr(8'h07, 8'h03);
    repeat (200) @(negedge clk);
    wr(8'h07, 8'h02);
    repeat (200) @(negedge clk);
    wr(8'h07, 8'h01);
    repeat (5) @(negedge clk);
    begin
      int n_stb;
      logic [9:0] held;
      n_stb = 0; held = mix_left;
      for (int i = 0; i < 100; i++) begin
        if (mix_strobe) n_stb++;
        @(negedge clk);
      end
      chk(n_stb == 0, "R7", n_stb, 0);
      chk(mix_left == held, "R7", int'(mix_left), int'(held));
    end
    wr(8'h07, 8'h00);
    repeat (100) @(negedge clk);

    // R9: writes landing on a tick edge
    cur_req = "R9";
    sync_to_tick();
    wr(8'h11, 8'h40);
    repeat (100) @(negedge clk);
    sync_to_tick();
    wr(8'h1E, 8'h20);
    repeat (100) @(negedge clk);

    // R8: leave wavetable mode during a fetch
    cur_req = "R8";
    sync_to_tick();
    @(negedge clk);
    mode_sel = 2'd0;
    @(negedge clk);
    chk(mix_left == 10'd0, "R8", int'(mix_left), 0);
    chk(mix_strobe == 1'b0, "R8", int'(mix_strobe), 0);
    wr24(8'h10, 24'h123000);
    repeat (50) @(negedge clk);
    mode_sel = 2'd2;
    repeat (150) @(negedge clk);

    // R5: extreme sums
    cur_req = "R5";
    for (int v = 0; v < 4; v++) wr24(8'(16 + 8 * v + 4), 24'h000000);
    for (int v = 0; v < 4; v++) wr24(8'(16 + 8 * v), 24'hFF8000);
    wait_strobe(); @(negedge clk); wait_strobe();
    chk(mix_left == 10'h200, "R5", int'(mix_left), 'h200);
    chk(mix_right == 10'h200, "R5", int'(mix_right), 'h200);
    for (int v = 0; v < 4; v++) wr24(8'(16 + 8 * v), 24'hFF0000);
    wait_strobe(); @(negedge clk); wait_strobe();
    chk(mix_left == 10'h1FC, "R5", int'(mix_left), 'h1FC);
    repeat (40) @(negedge clk);

    cmp_on = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule